// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks the way of a four-way set-associative cache that takes the next line fill after a miss. The cache controller pulses an allocate strobe each time it fills a line. On each strobe the selector moves its victim pointer forward. In sequential mode the pointer steps by one. In pseudorandom mode it steps by an amount of one to three, drawn from a small linear feedback shift register.

A programmable floor sets the lowest way the pointer may select. When a step would carry the pointer past the top way, the pointer wraps back into the window that runs from the floor to the top way. Ways below the floor are therefore never chosen for replacement, which locks their lines in place. Writing a new floor value also moves the pointer onto that floor straight away.

Top module: `victim_way_sel`

## Requirements
- R1: While reset is asserted and after it is released, with no other stimulus, the victim output is 0 and the floor is 0.
- R2: In any cycle where neither the allocate strobe nor the floor write is asserted, the victim output holds its value.
- R3: With mode_i = 0 (sequential), each allocation moves the victim to the next way up: floor 0 gives the sequence 0, 1, 2, 3, 0.
- R4: With mode_i = 1 (pseudorandom), each allocation adds a step to the victim pointer. The step is taken from bits [1:0] of an 8-bit shift register, and a value of 0 is replaced by 1. The register resets to 8'h01 and shifts left once per allocation in either mode. The new bit 0 is the XOR of bits 7, 5, 4 and 3, and each step uses the register value from before that shift.
- R5: When pointer + step exceeds 3, the victim becomes floor + ((pointer + step − 4) mod (4 − floor)).
- R6: A floor write loads both the floor and the victim pointer with base_i at the next clock edge. It takes priority over an allocation in the same cycle, although that allocation still shifts the register.
- R7: The victim output is never below the current floor.
- R8: With the floor at 3, the victim stays at way 3 under any number of allocations in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | 0 = sequential step, 1 = pseudorandom step |
| alloc_i | input | 1 | Line fill strobe that advances the pointer |
| base_wr_i | input | 1 | Floor write strobe |
| base_i | input | 2 | New floor value |
| victim_o | output | 2 | Way to replace on the next fill |

## Verification
The bench builds the block with its default parameters: four ways, a two-bit step and an 8-bit shift register with seed 8'h01. With only four ways, every floor value from 0 to 3 can be reached, and so can every wrap case, including the one-way window where each step folds back onto way 3. A two-bit step together with a two-way window makes the modulo fold in R5 act on a remainder of up to 2. Long pseudorandom runs then follow the shift register through many states and compare the victim on every allocation.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic {
    VWS_SEQ  = 1'b0,
    VWS_RAND = 1'b1
  } vws_mode_e;
endpackage

// File: rtl/vws_lfsr.sv
module vws_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: a maximal-length register never reaches the all-zero state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/vws_step.sv
module vws_step
  import vws_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  vws_mode_e         mode_i,
  input  logic [STEP_W-1:0] rnd_i,
  output logic [STEP_W-1:0] step_o
);
  always_comb begin
    if (mode_i == VWS_SEQ)  step_o = STEP_W'(1);
    else if (rnd_i == '0)   step_o = STEP_W'(1);
    else                    step_o = rnd_i;
  end
endmodule

// File: rtl/vws_counter.sv
module vws_counter #(
  parameter int WAYS   = 4,
  parameter int STEP_W = 2,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              base_wr_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [IDX_W-1:0]  victim_o
);
  localparam int SUM_W = IDX_W + STEP_W + 1;
  localparam int MAXV  = WAYS - 1;
  localparam int NFOLD = 1 << STEP_W;

  logic [IDX_W-1:0] cnt_q, cnt_d, base_q;
  logic [SUM_W-1:0] sum, over, span;
  logic             cnt_en;

  assign cnt_en = alloc_i | base_wr_i;

  always_comb begin
    sum  = SUM_W'(cnt_q) + SUM_W'(step_i);
    span = SUM_W'(MAXV) - SUM_W'(base_q) + SUM_W'(1);
    over = '0;
    if (base_wr_i) begin
      cnt_d = base_i;
    end else if (sum > SUM_W'(MAXV)) begin
      over = sum - SUM_W'(WAYS);
      for (int i = 0; i < NFOLD; i++) begin
        if (over >= span) over = over - span;
      end
      cnt_d = base_q + over[IDX_W-1:0];
    end else begin
      cnt_d = sum[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (base_wr_i) base_q <= base_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign victim_o = cnt_q;

  a_r7_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    victim_o >= base_q);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_i && !base_wr_i) |=> $stable(victim_o));

  a_r6_load_floor: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_i |=> (victim_o == $past(base_i)));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !base_wr_i && step_i == STEP_W'(1) && victim_o != IDX_W'(MAXV))
      |=> (victim_o == $past(victim_o) + IDX_W'(1)));

  a_r8_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == IDX_W'(MAXV) && !base_wr_i) |=> (victim_o == IDX_W'(MAXV)));
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import vws_pkg::*;
#(
  parameter int          WAYS   = 4,
  parameter int          STEP_W = 2,
  parameter int          LFSR_W = 8,
  parameter logic [7:0]  TAPS   = 8'hB8,
  parameter logic [7:0]  SEED   = 8'h01,
  localparam int         IDX_W  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             alloc_i,
  input  logic             base_wr_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [IDX_W-1:0] victim_o
);
  logic              rst_meta, rst_q;
  logic [LFSR_W-1:0] rnd;
  logic [STEP_W-1:0] step;
  vws_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign mode = vws_mode_e'(mode_i);

  vws_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(TAPS)), .SEED(LFSR_W'(SEED))) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_q),
    .adv_i   (alloc_i),
    .state_o (rnd)
  );

  vws_step #(.STEP_W(STEP_W)) u_step (
    .mode_i (mode),
    .rnd_i  (rnd[STEP_W-1:0]),
    .step_o (step)
  );

  vws_counter #(.WAYS(WAYS), .STEP_W(STEP_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_q),
    .alloc_i   (alloc_i),
    .base_wr_i (base_wr_i),
    .base_i    (base_i),
    .step_i    (step),
    .victim_o  (victim_o)
  );

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_q |=> (victim_o == '0) || !rst_q);
endmodule

// File: tb/victim_way_sel_test.sv
module victim_way_sel_test;
  logic       clk = 1'b0;
  logic       rst_n, mode_i, alloc_i, base_wr_i;
  logic [1:0] base_i;
  logic [1:0] victim_o;

  int errors = 0;
  int checks = 0;
  int m_cnt, m_base;
  logic [7:0] m_lfsr;

  always #4 clk = ~clk;

  victim_way_sel uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .alloc_i(alloc_i),
    .base_wr_i(base_wr_i), .base_i(base_i), .victim_o(victim_o)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(victim_o) != exp) begin
      errors++;
      $display("FAIL %s: victim=%0d expected=%0d", req, victim_o, exp);
    end
  endtask

  task automatic model_step(input logic a, input logic w, input int b, input logic m);
    int st, s, o, sp;
    st = 1;
    if (m && m_lfsr[1:0] != 2'b00) st = int'(m_lfsr[1:0]);
    if (w) begin
      m_base = b; m_cnt = b;
    end else if (a) begin
      s = m_cnt + st;
      if (s > 3) begin
        o = s - 4; sp = 4 - m_base;
        while (o >= sp) o = o - sp;
        m_cnt = m_base + o;
      end else m_cnt = s;
    end
    if (a) m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
  endtask

  task automatic cyc(input logic a, input logic w, input int b, input logic m);
    alloc_i = a; base_wr_i = w; base_i = 2'(b); mode_i = m;
    model_step(a, w, b, m);
    @(posedge clk);
    @(negedge clk);
    alloc_i = 1'b0; base_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; alloc_i = 0; base_wr_i = 0; base_i = 0; mode_i = 0;
    m_cnt = 0; m_base = 0; m_lfsr = 8'h01;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 0);
  endtask

  task automatic t_hold;
    repeat (5) @(negedge clk);
    check("R2 idle hold", m_cnt);
  endtask

  task automatic t_seq;
    int seq[4] = '{1, 2, 3, 0};
    foreach (seq[i]) begin
      cyc(1, 0, 0, 0);
      check("R3 sequential", seq[i]);
    end
  endtask

  task automatic t_floor;
    cyc(0, 1, 2, 0);
    check("R6 floor load", 2);
    cyc(1, 0, 0, 0); check("R3 step in window", 3);
    cyc(1, 0, 0, 0); check("R5 wrap to floor", 2);
    cyc(1, 1, 1, 0); check("R6 write beats alloc", 1);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 0, 0);
      check("R7 above floor", m_cnt);
      if (victim_o < 2'd1) begin errors++; $display("FAIL R7: victim=%0d expected>=1", victim_o); end
    end
  endtask

  task automatic t_locked;
    cyc(0, 1, 3, 1);
    for (int i = 0; i < 12; i++) begin
      cyc(1, 0, 0, i[0]);
      check("R8 only way 3", 3);
    end
  endtask

  task automatic t_rand(input int b, input int n);
    cyc(0, 1, b, 1);
    check("R6 floor load", b);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 1);
      check("R4 R5 pseudorandom", m_cnt);
    end
    repeat (3) @(negedge clk);
    check("R2 hold after run", m_cnt);
  endtask

  task automatic t_mixed;
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, 0, (i % 3) == 0);
      check("R3 R4 mixed modes", m_cnt);
    end
  endtask

  initial begin
    t_reset();
    t_hold();
    t_seq();
    t_floor();
    t_locked();
    t_rand(0, 60);
    t_rand(1, 60);
    t_rand(2, 60);
    t_mixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule